// File: doc/BRIEF.md
# Six-Channel DMA Channel Controller

This block is the control plane of a small DMA engine that moves data between on-chip RAM and peripheral registers. Each of six channels holds a control byte, a 16-bit transfer counter, a RAM pointer and a peripheral pointer. Software programs all four over a simple write/read register bus.

Each channel has four interrupt request lines of its own. A 2-bit field in the control byte picks which of them starts a transfer. An accepted trigger becomes a pending request. A fixed-priority arbiter turns pending requests into single transfer requests toward a bus interface, one at a time. Each request carries the channel number, the direction, the data size and both addresses. The bus interface moves the data and acknowledges with a one-cycle done strobe.

After each acknowledged transfer, the counter steps down and the RAM pointer steps forward. When the counter goes from 1 to 0, the channel:
- raises its completion flag,
- drops its enable,
- emits a one-cycle interrupt pulse.

Register address is `{channel[2:0], select[1:0]}` with select 0 = control, 1 = count, 2 = RAM address, 3 = peripheral address. Reads return the addressed register one cycle after the address is presented.

Top module: `dma_ctrl`

## Requirements
- R1: After reset every control byte reads 0x00, no transfer request is active and no completion pulse is high.
- R2: A control write stores bits 5:0 (bit 0 enable, bit 1 size, bit 2 direction, bits 4:3 trigger select, bit 5 address-control). Bit 6 always reads 0. Writing 1 to bit 7 does not set the completion flag.
- R3: Any write to a channel's control byte clears its completion flag (bit 7).
- R4: Trigger select value k (0..3) makes only request line `irq[4*ch+k]` start that channel; pulses on the channel's other three lines do nothing.
- R5: A trigger on a channel whose enable bit is 0 issues no transfer.
- R6: A transfer request presents the channel number, the direction bit (0 = RAM to peripheral, 1 = peripheral to RAM), the size bit (0 = 8-bit, 1 = 16-bit), the current RAM address and the peripheral address. It holds them until the done strobe.
- R7: After each completed transfer the RAM address grows by 1 for 8-bit and by 2 for 16-bit transfers, and the peripheral address stays unchanged.
- R8: Each completed transfer decrements the count. On the transfer that takes it from 1 to 0, the completion flag becomes 1 and enable becomes 0, so later triggers are ignored.
- R9: On that final transfer the channel's `done_irq` bit is high for exactly one cycle.
- R10: When several channels are pending together, the lowest-numbered one is issued first, and only one transfer is outstanding at a time.
- R11: Any number of triggers arriving while a channel's transfer is outstanding produce at most one further transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | `{channel, select}` register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| irq | input | 24 | Four trigger lines per channel, channel n on bits 4n+3..4n |
| xfer_req | output | 1 | Transfer request, held until `xfer_done` |
| xfer_ch | output | 3 | Channel of the outstanding request |
| xfer_dir | output | 1 | 0 = RAM to peripheral, 1 = peripheral to RAM |
| xfer_size | output | 1 | 0 = 8-bit, 1 = 16-bit |
| xfer_ram_addr | output | 16 | RAM address for this transfer |
| xfer_per_addr | output | 16 | Peripheral address for this transfer |
| xfer_done | input | 1 | One-cycle acknowledge from the bus interface |
| done_irq | output | 6 | One-cycle completion pulse per channel |

## Verification
The assertions assume that the bus interface raises `xfer_done` only while `xfer_req` is high, for a single cycle per request. They also assume that software does not rewrite a channel's count or control in the same cycle as that channel's final acknowledge. The bench's bus model waits for a request, stays busy for a programmable number of cycles, copies the data between its RAM and peripheral arrays, then strobes done once and waits for the request to drop. All register writes are made while the channel concerned is idle.

// File: rtl/dma_pkg.sv
package dma_pkg;
  // control byte bit positions (software visible)
  localparam int CTRL_EN   = 0;
  localparam int CTRL_SZ   = 1;
  localparam int CTRL_DIR  = 2;
  localparam int CTRL_TSL  = 3;   // two bits, 4:3
  localparam int CTRL_ADC  = 5;
  localparam int CTRL_TC   = 7;
  localparam int NSRC      = 4;   // trigger lines per channel

  // register select codes (low two address bits)
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_RAM  = 2'd2;
  localparam logic [1:0] SEL_PER  = 2'd3;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [NSRC-1:0] trig_src,
  input  logic            grant,
  input  logic            done_hit,
  output logic [7:0]      ctrl,
  output logic [CW-1:0]   count,
  output logic [AW-1:0]   ram_addr,
  output logic [AW-1:0]   per_addr,
  output logic            pend,
  output logic            done_pulse
);
  logic       tc, en, size, dir, adc;
  logic [1:0] tsel;
  logic       trig, last;
  logic [AW-1:0] step;

  assign ctrl = {tc, 1'b0, adc, tsel, dir, size, en};
  assign trig = trig_src[tsel];
  assign last = done_hit && (count == CW'(1));
  assign step = size ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tc <= 1'b0; en <= 1'b0; size <= 1'b0; dir <= 1'b0; adc <= 1'b0;
      tsel <= 2'd0; count <= '0; ram_addr <= '0; per_addr <= '0;
      pend <= 1'b0; done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: begin
            tc   <= 1'b0;
            adc  <= wr_data[CTRL_ADC];
            tsel <= wr_data[CTRL_TSL +: 2];
            dir  <= wr_data[CTRL_DIR];
            size <= wr_data[CTRL_SZ];
            en   <= wr_data[CTRL_EN];
          end
          SEL_CNT: count    <= wr_data[CW-1:0];
          SEL_RAM: ram_addr <= wr_data[AW-1:0];
          default: per_addr <= wr_data[AW-1:0];
        endcase
      end
      // pending request: one bit, so extra triggers collapse
      if (grant) pend <= 1'b0;
      if (trig && en) pend <= 1'b1;
      if (wr_en && wr_sel == SEL_CTRL && !wr_data[CTRL_EN]) pend <= 1'b0;
      // completion has priority over a simultaneous software write
      if (done_hit) begin
        count    <= count - CW'(1);
        ram_addr <= ram_addr + step;
        if (last) begin
          tc         <= 1'b1;
          en         <= 1'b0;
          pend       <= 1'b0;
          done_pulse <= 1'b1;
        end
      end
    end
  end

  assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> !done_pulse);
  assert_tc_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(tc) |-> (count == '0 && !en));
  assert_pend_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(en));
  assert_per_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    (done_hit && !wr_en) |=> $stable(per_addr));
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NUM_CH = 6,
  parameter int CHW    = 3
) (
  input  logic [NUM_CH-1:0] pend,
  input  logic              idle,
  output logic              gnt_any,
  output logic [CHW-1:0]    gnt_idx
);
  // fixed priority: scan downward so the lowest set index is left last
  always_comb begin
    gnt_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend[i]) gnt_idx = CHW'(i);
    end
    gnt_any = idle && (|pend);
  end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CW     = 16,
  parameter int AW     = 16,
  parameter int DW     = 16,
  localparam int CHW    = $clog2(NUM_CH),
  localparam int ADDR_W = CHW + 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic [NUM_CH*NSRC-1:0] irq,
  output logic                   xfer_req,
  output logic [CHW-1:0]         xfer_ch,
  output logic                   xfer_dir,
  output logic                   xfer_size,
  output logic [AW-1:0]          xfer_ram_addr,
  output logic [AW-1:0]          xfer_per_addr,
  input  logic                   xfer_done,
  output logic [NUM_CH-1:0]      done_irq
);
  logic [7:0]    ch_ctrl [NUM_CH];
  logic [CW-1:0] ch_cnt  [NUM_CH];
  logic [AW-1:0] ch_ram  [NUM_CH];
  logic [AW-1:0] ch_per  [NUM_CH];
  logic [NUM_CH-1:0] pend;
  logic          gnt_any;
  logic [CHW-1:0] gnt_idx;
  logic [CHW-1:0] a_ch;
  logic [1:0]    a_sel;

  assign a_ch  = reg_addr[ADDR_W-1:2];
  assign a_sel = reg_addr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_chan #(.CW(CW), .AW(AW), .DW(DW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_we && a_ch == CHW'(i)),
      .wr_sel    (a_sel),
      .wr_data   (reg_wdata),
      .trig_src  (irq[i*NSRC +: NSRC]),
      .grant     (gnt_any && gnt_idx == CHW'(i)),
      .done_hit  (xfer_done && xfer_req && xfer_ch == CHW'(i)),
      .ctrl      (ch_ctrl[i]),
      .count     (ch_cnt[i]),
      .ram_addr  (ch_ram[i]),
      .per_addr  (ch_per[i]),
      .pend      (pend[i]),
      .done_pulse(done_irq[i])
    );
  end

  dma_arb #(.NUM_CH(NUM_CH), .CHW(CHW)) u_arb (
    .pend   (pend),
    .idle   (!xfer_req),
    .gnt_any(gnt_any),
    .gnt_idx(gnt_idx)
  );

  // single outstanding transfer, registered toward the bus interface
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_req <= 1'b0; xfer_ch <= '0; xfer_dir <= 1'b0; xfer_size <= 1'b0;
      xfer_ram_addr <= '0; xfer_per_addr <= '0;
    end else if (xfer_req) begin
      if (xfer_done) xfer_req <= 1'b0;
    end else if (gnt_any) begin
      xfer_req      <= 1'b1;
      xfer_ch       <= gnt_idx;
      xfer_dir      <= ch_ctrl[gnt_idx][CTRL_DIR];
      xfer_size     <= ch_ctrl[gnt_idx][CTRL_SZ];
      xfer_ram_addr <= ch_ram[gnt_idx];
      xfer_per_addr <= ch_per[gnt_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (int'(a_ch) < NUM_CH) begin
      case (a_sel)
        SEL_CTRL: reg_rdata <= DW'(ch_ctrl[a_ch]);
        SEL_CNT:  reg_rdata <= DW'(ch_cnt[a_ch]);
        SEL_RAM:  reg_rdata <= DW'(ch_ram[a_ch]);
        default:  reg_rdata <= DW'(ch_per[a_ch]);
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end

  assert_req_held_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_ch)
      && $stable(xfer_ram_addr) && $stable(xfer_dir) && $stable(xfer_size)));
  assert_done_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> xfer_req);
  assert_one_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(done_irq) <= 1);
endmodule

// File: tb/sim_dma_ctrl.sv
module sim_dma_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [23:0] irq = '0;
  logic        xfer_req, xfer_dir, xfer_size;
  logic [2:0]  xfer_ch;
  logic [15:0] xfer_ram_addr, xfer_per_addr;
  logic        xfer_done = 1'b0;
  logic [5:0]  done_irq;

  int nchk = 0, nfail = 0;
  int nlog = 0;
  int bus_delay = 1;
  int log_ch [64];
  int log_ram [64];
  int log_per [64];
  int log_dir [64];
  int log_sz [64];
  int irq_seen [6];
  logic [7:0] ram_mem [512];
  logic [7:0] per_mem [256];

  always #10 clk = ~clk;   // 50 MHz

  dma_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch), .xfer_dir(xfer_dir),
    .xfer_size(xfer_size), .xfer_ram_addr(xfer_ram_addr),
    .xfer_per_addr(xfer_per_addr), .xfer_done(xfer_done), .done_irq(done_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(ch * 4 + sel); reg_wdata = 16'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output int v);
    @(negedge clk);
    reg_addr = 5'(ch * 4 + sel);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic pulse(input logic [23:0] lines);
    @(negedge clk);
    irq = lines;
    @(negedge clk);
    irq = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bus interface model: log, wait, move data, strobe done once
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req && !xfer_done) begin
        log_ch[nlog] = int'(xfer_ch); log_ram[nlog] = int'(xfer_ram_addr);
        log_per[nlog] = int'(xfer_per_addr); log_dir[nlog] = int'(xfer_dir);
        log_sz[nlog] = int'(xfer_size);
        if (nlog < 63) nlog++;
        repeat (bus_delay) @(negedge clk);
        for (int b = 0; b < (xfer_size ? 2 : 1); b++) begin
          if (xfer_dir) ram_mem[9'(xfer_ram_addr + 16'(b))] = per_mem[8'(xfer_per_addr + 16'(b))];
          else          per_mem[8'(xfer_per_addr + 16'(b))] = ram_mem[9'(xfer_ram_addr + 16'(b))];
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      for (int c = 0; c < 6; c++) if (done_irq[c]) irq_seen[c]++;
    end
  end

  task automatic t_reset();
    int v;
    for (int c = 0; c < 6; c++) begin
      rd(c, 0, v);
      check("R1 ctrl reset", v, 0);
    end
    check("R1 no request", int'(xfer_req), 0);
    check("R1 no pulse", int'(done_irq), 0);
  endtask

  task automatic t_regs();
    int v;
    wr(1, 0, 'hFF);
    rd(1, 0, v);
    check("R2 bit6 zero, bit7 not settable", v, 'h3F);
    wr(1, 0, 'h00);
    rd(1, 0, v);
    check("R2 control cleared", v, 'h00);
  endtask

  task automatic t_basic();
    int v, base;
    per_mem[8'h40] = 8'hAB; per_mem[8'h41] = 8'hCD;
    bus_delay = 1;
    wr(0, 1, 3); wr(0, 2, 'h100); wr(0, 3, 'h40);
    wr(0, 0, 'h17);                     // en, 16-bit, periph->RAM, line 2
    base = nlog;
    pulse(24'h00000B);                  // lines 0,1,3 of channel 0
    settle(10);
    check("R4 unselected lines ignored", nlog - base, 0);
    for (int k = 0; k < 3; k++) begin
      pulse(24'h000004);
      settle(10);
    end
    check("R4 selected line starts 3 transfers", nlog - base, 3);
    for (int k = 0; k < 3; k++) begin
      check("R6 channel", log_ch[base+k], 0);
      check("R6 direction", log_dir[base+k], 1);
      check("R6 size", log_sz[base+k], 1);
      check("R7 peripheral fixed", log_per[base+k], 'h40);
      check("R7 RAM step 2", log_ram[base+k], 'h100 + 2 * k);
    end
    check("R6 data moved", int'({ram_mem[9'h104], ram_mem[9'h105]}), 'hABCD);
    rd(0, 1, v);
    check("R8 count zero", v, 0);
    rd(0, 0, v);
    check("R8 flag set, enable clear", v, 'h96);
    check("R9 one pulse", irq_seen[0], 1);
    pulse(24'h000004);
    settle(10);
    check("R8 disabled after terminal count", nlog - base, 3);
    wr(0, 0, 'h16);
    rd(0, 0, v);
    check("R3 write clears flag", v, 'h16);
  endtask

  task automatic t_disabled();
    int base;
    wr(2, 1, 1);
    wr(2, 0, 'h00);
    base = nlog;
    pulse(24'h000100);
    settle(10);
    check("R5 no transfer while disabled", nlog - base, 0);
  endtask

  task automatic t_priority();
    int base, v;
    bus_delay = 2;
    wr(5, 1, 1); wr(5, 2, 'h20); wr(5, 0, 'h19);   // en, 8-bit, line 3
    wr(3, 1, 1); wr(3, 2, 'h30); wr(3, 0, 'h01);   // en, 8-bit, line 0
    base = nlog;
    pulse(24'h801000);                 // channel 5 line 3 and channel 3 line 0
    settle(20);
    check("R10 two transfers", nlog - base, 2);
    check("R10 lower channel first", log_ch[base], 3);
    check("R10 then higher channel", log_ch[base+1], 5);
    check("R6 RAM to periph direction", log_dir[base], 0);
    check("R9 pulse ch3", irq_seen[3], 1);
    check("R9 pulse ch5", irq_seen[5], 1);
    rd(5, 0, v);
    check("R8 ch5 flag", v, 'h98);
  endtask

  task automatic t_step8();
    int base, v;
    bus_delay = 0;
    wr(4, 1, 2); wr(4, 2, 'h10); wr(4, 3, 'h07); wr(4, 0, 'h11);  // line 2
    base = nlog;
    pulse(24'h040000); settle(8);
    pulse(24'h040000); settle(8);
    check("R7 two byte transfers", nlog - base, 2);
    check("R7 first RAM addr", log_ram[base], 'h10);
    check("R7 RAM step 1", log_ram[base+1], 'h11);
    rd(4, 2, v);
    check("R7 RAM pointer after", v, 'h12);
    rd(4, 3, v);
    check("R7 periph pointer kept", v, 'h07);
  endtask

  task automatic t_collapse();
    int base, v;
    bus_delay = 10;
    wr(1, 1, 5); wr(1, 2, 'h80); wr(1, 0, 'h09);   // en, 8-bit, line 1
    base = nlog;
    pulse(24'h000020);
    settle(3);
    for (int k = 0; k < 4; k++) pulse(24'h000020);
    settle(60);
    check("R11 extra triggers collapse", nlog - base, 2);
    rd(1, 1, v);
    check("R11 count after two transfers", v, 3);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) ram_mem[i] = 8'(i);
    for (int i = 0; i < 256; i++) per_mem[i] = 8'(i ^ 8'h5A);
    for (int c = 0; c < 6; c++) irq_seen[c] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_basic();
    t_disabled();
    t_priority();
    t_step8();
    t_collapse();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule